// File: doc/BRIEF.md
# Look-Up-Table Dual-Read Memory

This block is a small register-file memory of the kind that maps onto the look-up tables of a programmable logic fabric. Each storage cell holds sixteen one-bit words. A bank places one cell per data bit, and all of them share address and control, so a bank holds sixteen words of any width. Setting the cascade parameter puts two banks side by side and adds an extra, most significant address bit that chooses between them, giving thirty-two words.

There is one write port. Its address also drives a first read output, so the word at the write location can always be seen. A second read output has an address of its own, fully independent of the write address. Both reads are combinational by default: each output follows its addressed word without a clock. A parameter places a flip-flop stage after the read multiplexers. This makes both reads synchronous with one cycle of latency. The synchronous reset clears only that output stage and never the stored words.

Top module: `lut_dpram`

## Requirements
- R1: With the cascade enabled (default), the memory holds 32 independent words. Write and read address bit 4 selects the upper bank when 1 and the lower bank when 0. Bits 3..0 pick the word inside the bank.
- R2: On a rising `clk` edge with `wr_en` = 1, `wr_data` is stored at `wr_addr`.
- R3: On a rising edge with `wr_en` = 0, no stored word changes, whatever `wr_addr` and `wr_data` carry.
- R4: With the output stage off, `rd_q` shows the word at `rd_addr` and `wa_q` shows the word at `wr_addr`. Both follow their addresses combinationally and independently of each other.
- R5: With the output stage off, a read of the location being written shows the old word until the write edge and the new word right after it. There is no bypass of `wr_data`.
- R6: With the output stage on, each output shows the word its address selected at the previous rising edge. A word written on that same edge is seen as its old value.
- R7: With the output stage on, `rst` = 1 at a rising edge sets both outputs to zero and leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, also clocks the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W (5) | Write address, also the address of `wa_q` |
| wr_data | input | DATA_W (8) | Data to be written |
| rd_addr | input | ADDR_W (5) | Independent read address |
| wa_q | output | DATA_W (8) | Word at the write address |
| rd_q | output | DATA_W (8) | Word at the read address |

## Verification
The assertions check the following on every cycle. Every enabled write lands at the addressed bit of each cell. Every idle edge leaves the cell contents unchanged. The registered outputs carry exactly the value presented one edge earlier, and a reset edge leaves them at zero. The bench scenarios are needed for the rest: how the two banks separate under the extra address bit, the old-then-new order seen on a same-address read in combinational mode, the old value captured by the output stage during a write to the same address, and the survival of the stored words across a reset.

// File: rtl/lut_dpram_pkg.sv
package lut_dpram_pkg;
  localparam int CELL_DEPTH = 16;
  localparam int CELL_AW    = 4;

  function automatic int bank_count(int cascade);
    return (cascade != 0) ? 2 : 1;
  endfunction
endpackage

// File: rtl/lut_cell.sv
module lut_cell
  import lut_dpram_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [CELL_AW-1:0] wa,
  input  logic               wd,
  input  logic [CELL_AW-1:0] ra,
  output logic               wa_bit,
  output logic               ra_bit
);
  logic [CELL_DEPTH-1:0] bits;

  always_ff @(posedge clk) begin
    if (we) bits[wa] <= wd;
  end

  assign wa_bit = bits[wa];
  assign ra_bit = bits[ra];

  AST_CELL_WRITE: assert property (@(posedge clk) disable iff (rst)
    we |=> bits[$past(wa)] == $past(wd)); // R2
  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(bits)); // R3
endmodule

// File: rtl/lut_bank.sv
module lut_bank
  import lut_dpram_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [CELL_AW-1:0] wa,
  input  logic [DATA_W-1:0]  wd,
  input  logic [CELL_AW-1:0] ra,
  output logic [DATA_W-1:0]  wa_word,
  output logic [DATA_W-1:0]  ra_word
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    lut_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .we    (we),
      .wa    (wa),
      .wd    (wd[i]),
      .ra    (ra),
      .wa_bit(wa_word[i]),
      .ra_bit(ra_word[i])
    );
  end
endmodule

// File: rtl/word_sel.sv
module word_sel #(
  parameter int DATA_W = 8,
  parameter int NB     = 2
) (
  input  logic [NB-1:0][DATA_W-1:0] words,
  input  logic                      sel,
  output logic [DATA_W-1:0]         word
);
  if (NB > 1) begin : g_mux
    assign word = sel ? words[1] : words[0];
  end else begin : g_pass
    logic unused_sel;
    assign unused_sel = sel;
    assign word = words[0];
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DATA_W = 8,
  parameter int OUT_REG = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end

    AST_REG_LATENCY: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> q == $past(d)); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> q == '0); // R7
  end else begin : g_comb
    logic unused_clk, unused_rst;
    assign unused_clk = clk;
    assign unused_rst = rst;
    assign q = d;
  end
endmodule

// File: rtl/lut_dpram.sv
module lut_dpram
  import lut_dpram_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CASCADE = 1,
  parameter int OUT_REG = 0,
  parameter int ADDR_W  = CELL_AW + ((CASCADE != 0) ? 1 : 0)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] wa_q,
  output logic [DATA_W-1:0] rd_q
);
  localparam int NB = bank_count(CASCADE);

  logic [NB-1:0][DATA_W-1:0] bank_wq, bank_rq;
  logic                      wr_bank, rd_bank;
  logic [DATA_W-1:0]         wa_word, rd_word;

  if (NB > 1) begin : g_sel
    assign wr_bank = wr_addr[ADDR_W-1];
    assign rd_bank = rd_addr[ADDR_W-1];
  end else begin : g_nosel
    assign wr_bank = 1'b0;
    assign rd_bank = 1'b0;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    lut_bank #(.DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_en && (wr_bank == 1'(b))),
      .wa     (wr_addr[CELL_AW-1:0]),
      .wd     (wr_data),
      .ra     (rd_addr[CELL_AW-1:0]),
      .wa_word(bank_wq[b]),
      .ra_word(bank_rq[b])
    );
  end

  word_sel #(.DATA_W(DATA_W), .NB(NB)) u_wsel (
    .words(bank_wq), .sel(wr_bank), .word(wa_word)
  );
  word_sel #(.DATA_W(DATA_W), .NB(NB)) u_rsel (
    .words(bank_rq), .sel(rd_bank), .word(rd_word)
  );

  out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_wout (
    .clk(clk), .rst(rst), .d(wa_word), .q(wa_q)
  );
  out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_rout (
    .clk(clk), .rst(rst), .d(rd_word), .q(rd_q)
  );
endmodule

// File: tb/tb_lut_dpram.sv
module tb_lut_dpram;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [4:0] V_WA [NV] = '{5'd3, 5'd3, 5'd19, 5'd19, 5'd0, 5'd31, 5'd16, 5'd15};
  localparam logic [7:0] V_WD [NV] = '{8'hAA, 8'h55, 8'hC3, 8'h0F, 8'hFF, 8'h01, 8'h80, 8'h7E};
  localparam logic [4:0] V_RA [NV] = '{5'd3, 5'd19, 5'd3, 5'd19, 5'd31, 5'd0, 5'd16, 5'd16};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] wa_q, rd_q, s_wa_q, s_rd_q;
  logic [7:0] model [32];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_dpram #(.DATA_W(8), .CASCADE(1), .OUT_REG(0)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .wa_q(wa_q), .rd_q(rd_q));
  lut_dpram #(.DATA_W(8), .CASCADE(1), .OUT_REG(1)) dut_sync (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .wa_q(s_wa_q), .rd_q(s_rd_q));

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] old_r, old_w;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    check("R7 reset rd", s_rd_q, 8'h00);
    check("R7 reset wa", s_wa_q, 8'h00);
    rst = 1'b0;

    // R2: fill every word
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(a * 37 + 11);
      model[a] = 8'(a * 37 + 11);
    end
    @(negedge clk); wr_en = 1'b0;

    // R1 / R4: independent readback of both banks
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      rd_addr = 5'(a); wr_addr = 5'(31 - a); #1;
      check("R1 R4 rd", rd_q, model[a]);
      check("R4 wa", wa_q, model[31 - a]);
    end

    // vector table: R5 old-then-new, R6 registered capture, R1 bank isolation
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = V_WA[v]; wr_data = V_WD[v]; rd_addr = V_RA[v]; #1;
      check("R5 before edge", rd_q, model[V_RA[v]]);
      old_r = model[V_RA[v]];
      old_w = model[V_WA[v]];
      @(posedge clk);
      model[V_WA[v]] = V_WD[v];
      @(negedge clk);
      wr_en = 1'b0; #1;
      check("R5 after edge", rd_q, model[V_RA[v]]);
      check("R2 wa", wa_q, V_WD[v]);
      check("R6 rd old", s_rd_q, old_r);
      check("R6 wa old", s_wa_q, old_w);
    end

    // R3: disabled write with live address and data
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 5'd5; wr_data = ~model[5]; rd_addr = 5'd5;
    @(posedge clk);
    @(negedge clk); #1;
    check("R3 rd", rd_q, model[5]);
    check("R3 wa", wa_q, model[5]);

    // R6: latency of one edge
    @(negedge clk);
    rd_addr = 5'd7; #1;
    check("R6 pre-edge", s_rd_q, model[5]);
    @(negedge clk); #1;
    check("R6 post-edge", s_rd_q, model[7]);

    // R7: mid-run reset keeps contents
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    check("R7 rd clear", s_rd_q, 8'h00);
    check("R7 wa clear", s_wa_q, 8'h00);
    check("R7 contents", rd_q, model[7]);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R7 after release", s_rd_q, model[7]);
    check("R7 wa after release", s_wa_q, model[5]);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule